// File: doc/BRIEF.md
# Byte-Wide Bus Partition Decoder

This block sits between a processor's 16-bit address generator and a non-multiplexed byte-wide memory bus. For every program fetch or data access it decides, in one registered step, whether the cycle goes to the nonvolatile RAM, to one of two 16K peripheral windows, or out to the external multiplexed bus. It drives active-low chip enables for the RAM and both peripheral windows, an active-low read/write strobe, a routing flag for the external bus, and the low fourteen address bits of the byte-wide bus.

Two mapping modes exist. In the split mode a single 64K RAM is shared, and a 4-bit partition register decides which 4K pages hold program. Data-space writes into those pages are blocked: the RAM cycle still runs with the strobe kept high, and a one-cycle violation flag is raised. In the independent mode, separate program and data range registers set how many 4K pages of each space reach the RAM, and nothing is write-protected. A peripheral-select bit can take the upper half of data space away from the RAM and hand it to the two peripheral windows.

Top module: `bytewide_decoder`

## Requirements
- R1: While `rst` is high, the next clock edge drives `ramCeN`, `periphLoN`, `periphHiN` and `rwN` to 1, `extSel` and `wpViol` to 0, and `busAddr` to 0.
- R2: All outputs are registered: they take the decode of the inputs present at a clock edge and hold it until the next edge; with neither `rdReq` nor `wrReq` high, every enable and `rwN` are 1 and `extSel` and `wpViol` are 0.
- R3: With `modeFixed`=0, page p = `addr[15:12]` is program when p < `partReg` or `partReg`=4'hF. A fetch (`isCode`=1) to a program page drives `ramCeN` low; a fetch to any other page raises `extSel`. A data access to any page drives `ramCeN` low, and a data read or a write outside the program pages leaves `rwN` low only for writes.
- R4: With `modeFixed`=0, a data write to a program page drives `ramCeN` low, keeps `rwN` at 1, and raises `wpViol` for that one cycle only.
- R5: With `modeFixed`=1, a fetch reaches the RAM when page p <= `progRange` and a data access when p <= `dataRange`; otherwise `extSel` is raised. No write is blocked in this mode.
- R6: With `periphSel`=1, a data access with `addr[15]`=1 drives `periphLoN` low when `addr[14]`=0 and `periphHiN` low when `addr[14]`=1, leaves `ramCeN` at 1, is never write-protected, and drives `rwN` low for a write.
- R7: `busAddr` equals `addr[13:0]` one edge after it is presented, for every access kind.
- R8: At most one of RAM enable, the two peripheral enables and `extSel` is active in a cycle, and an external-bus cycle never drives `rwN` low.
- R9: A fetch is always a read: `wrReq` with `isCode`=1 never drives `rwN` low nor raises `wpViol`; with both requests high on a data access, the cycle is a write.
- R10: A change of `partReg` takes effect on the very next access, with no stale decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Access address |
| isCode | input | 1 | 1 = program fetch, 0 = data access |
| rdReq | input | 1 | Read request |
| wrReq | input | 1 | Write request |
| partReg | input | 4 | Partition boundary in 4K pages (split mode) |
| progRange | input | 4 | Highest RAM program page (independent mode) |
| dataRange | input | 4 | Highest RAM data page (independent mode) |
| modeFixed | input | 1 | 0 = split 64K RAM, 1 = independent ranges |
| periphSel | input | 1 | 1 = upper 32K of data space goes to peripheral windows |
| ramCeN | output | 1 | RAM chip enable, active low |
| periphLoN | output | 1 | Peripheral window 8000h-BFFFh enable, active low |
| periphHiN | output | 1 | Peripheral window C000h-FFFFh enable, active low |
| rwN | output | 1 | Write strobe, active low |
| extSel | output | 1 | Access routed to the external multiplexed bus |
| wpViol | output | 1 | Write blocked by program protection, one cycle |
| busAddr | output | 14 | Byte-wide address bus |

## Verification
Peripheral remapping and write protection can both claim the same data write: with `periphSel`=1 and `partReg`=4'hF, a write to 9000h lies in a program page yet also in the lower peripheral window. The bench provokes this and also writes to C000h and 7000h under the same settings, and the reference model judges that the peripheral decode wins (strobe low, no violation) while the write just below 8000h is blocked. A partition change presented in the same cycle as an access is also checked to decide that very access.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef struct packed {
    logic ramSel;
    logic loSel;
    logic hiSel;
    logic extSel;
    logic wrStrobe;
    logic protViol;
  } bwdStrobe_t;
endpackage

// File: rtl/bwd_ctrl.sv
module bwd_ctrl
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              isCode,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [PAGE_W-1:0] partReg,
  input  logic [PAGE_W-1:0] progRange,
  input  logic [PAGE_W-1:0] dataRange,
  input  logic              modeFixed,
  input  logic              periphSel,
  output bwdStrobe_t        strb
);
  localparam logic [PAGE_W-1:0] PAGE_ALL = '1;

  logic [PAGE_W-1:0] page;
  logic accessReq;
  logic isWrite;
  logic progPage;
  logic periphHit;
  logic ramMapped;

  assign page      = addr[ADDR_W-1 -: PAGE_W];
  assign accessReq = rdReq | wrReq;
  assign isWrite   = wrReq & ~isCode;
  assign progPage  = (partReg == PAGE_ALL) || (page < partReg);
  assign periphHit = periphSel & ~isCode & addr[ADDR_W-1];

  always_comb begin
    if (modeFixed) begin
      ramMapped = isCode ? (page <= progRange) : (page <= dataRange);
    end else begin
      ramMapped = isCode ? progPage : 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    if (accessReq) begin
      if (periphHit) begin
        strb.loSel    = ~addr[ADDR_W-2];
        strb.hiSel    = addr[ADDR_W-2];
        strb.wrStrobe = isWrite;
      end else if (ramMapped) begin
        strb.ramSel = 1'b1;
        if (isWrite) begin
          if (!modeFixed && progPage) begin
            strb.protViol = 1'b1;
          end else begin
            strb.wrStrobe = 1'b1;
          end
        end
      end else begin
        strb.extSel = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwd_dpath.sv
module bwd_dpath
  import bwd_pkg::*;
#(
  parameter int BUS_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  bwdStrobe_t       strb,
  input  logic [BUS_W-1:0] addrLow,
  output logic             ramCeN,
  output logic             periphLoN,
  output logic             periphHiN,
  output logic             rwN,
  output logic             extSel,
  output logic             wpViol,
  output logic [BUS_W-1:0] busAddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ramCeN    <= 1'b1;
      periphLoN <= 1'b1;
      periphHiN <= 1'b1;
      rwN       <= 1'b1;
      extSel    <= 1'b0;
      wpViol    <= 1'b0;
    end else begin
      ramCeN    <= ~strb.ramSel;
      periphLoN <= ~strb.loSel;
      periphHiN <= ~strb.hiSel;
      rwN       <= ~strb.wrStrobe;
      extSel    <= strb.extSel;
      wpViol    <= strb.protViol;
    end
  end

  for (genvar b = 0; b < BUS_W; b++) begin : g_busBit
    always_ff @(posedge clk) begin
      if (rst) busAddr[b] <= 1'b0;
      else     busAddr[b] <= addrLow[b];
    end
  end
endmodule

// File: rtl/bytewide_decoder.sv
module bytewide_decoder
  import bwd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isCode,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [PAGE_W-1:0] partReg,
  input  logic [PAGE_W-1:0] progRange,
  input  logic [PAGE_W-1:0] dataRange,
  input  logic              modeFixed,
  input  logic              periphSel,
  output logic              ramCeN,
  output logic              periphLoN,
  output logic              periphHiN,
  output logic              rwN,
  output logic              extSel,
  output logic              wpViol,
  output logic [ADDR_W-3:0] busAddr
);
  localparam int BUS_W = ADDR_W - 2;

  bwdStrobe_t strb;

  bwd_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .addr(addr), .isCode(isCode), .rdReq(rdReq), .wrReq(wrReq),
    .partReg(partReg), .progRange(progRange), .dataRange(dataRange),
    .modeFixed(modeFixed), .periphSel(periphSel), .strb(strb)
  );

  bwd_dpath #(.BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .addrLow(addr[BUS_W-1:0]),
    .ramCeN(ramCeN), .periphLoN(periphLoN), .periphHiN(periphHiN),
    .rwN(rwN), .extSel(extSel), .wpViol(wpViol), .busAddr(busAddr)
  );
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              isCode,
  input logic              periphSel,
  input logic              ramCeN,
  input logic              periphLoN,
  input logic              periphHiN,
  input logic              rwN,
  input logic              extSel,
  input logic              wpViol
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (ramCeN && periphLoN && periphHiN && rwN && !extSel && !wpViol)); // R1

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $countones({~ramCeN, ~periphLoN, ~periphHiN, extSel}) <= 1); // R8

  AST_EXT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    extSel |-> rwN); // R8

  AST_VIOL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    wpViol |-> (rwN && !ramCeN)); // R4

  AST_LO_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !periphLoN |-> ($past(periphSel) && !$past(isCode) && $past(addr[ADDR_W-1:ADDR_W-2]) == 2'b10)); // R6

  AST_HI_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !periphHiN |-> ($past(periphSel) && !$past(isCode) && $past(addr[ADDR_W-1:ADDR_W-2]) == 2'b11)); // R6

  AST_FETCH_READ: assert property (@(posedge clk) disable iff (rst)
    $past(isCode) |-> (rwN && !wpViol)); // R9
endmodule

bind bytewide_decoder bwd_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/bytewide_decoder_test.sv
module bytewide_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        isCode, rdReq, wrReq;
  logic [3:0]  partReg, progRange, dataRange;
  logic        modeFixed, periphSel;
  logic        ramCeN, periphLoN, periphHiN, rwN, extSel, wpViol;
  logic [13:0] busAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bytewide_decoder uut (
    .clk(clk), .rst(rst), .addr(addr), .isCode(isCode), .rdReq(rdReq), .wrReq(wrReq),
    .partReg(partReg), .progRange(progRange), .dataRange(dataRange),
    .modeFixed(modeFixed), .periphSel(periphSel),
    .ramCeN(ramCeN), .periphLoN(periphLoN), .periphHiN(periphHiN), .rwN(rwN),
    .extSel(extSel), .wpViol(wpViol), .busAddr(busAddr)
  );

  // expected outputs {ramCeN, periphLoN, periphHiN, rwN, extSel, wpViol, busAddr}
  logic [19:0] expVec;
  string       expTag;

  task automatic model();
    int pg;
    bit wr;
    bit prog;
    logic ram = 1, lo = 1, hi = 1, rw = 1, ext = 0, vio = 0;
    logic [13:0] ba = 0;
    pg = int'(addr) / 4096;
    if (rst) begin
      expTag = "R1";
    end else begin
      ba = addr[13:0];
      wr = wrReq && !isCode;
      if (!(rdReq || wrReq)) begin
        expTag = "R2";
      end else if (periphSel && !isCode && addr >= 16'h8000) begin
        if (addr < 16'hC000) lo = 0; else hi = 0;
        rw = !wr;
        expTag = "R6";
      end else if (modeFixed) begin
        if (pg <= int'(isCode ? progRange : dataRange)) begin
          ram = 0; rw = !wr;
        end else ext = 1;
        expTag = "R5";
      end else begin
        prog = (partReg == 4'hF) || (pg < int'(partReg));
        expTag = "R3";
        if (isCode) begin
          if (prog) ram = 0; else ext = 1;
        end else begin
          ram = 0;
          if (wr && prog) begin vio = 1; expTag = "R4"; end
          else rw = !wr;
        end
      end
    end
    expVec = {ram, lo, hi, rw, ext, vio, ba};
  endtask

  task automatic step(input logic [15:0] a, input bit code, input bit rd, input bit wr,
                      input string tagOver = "");
    logic [19:0] act;
    addr = a; isCode = code; rdReq = rd; wrReq = wr;
    model();
    if (tagOver != "") expTag = tagOver;
    @(posedge clk);
    @(negedge clk);
    act = {ramCeN, periphLoN, periphHiN, rwN, extSel, wpViol, busAddr};
    checks++;
    if (act !== expVec) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", expTag, a, act, expVec);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; addr = 0; isCode = 0; rdReq = 0; wrReq = 0;
    partReg = 4'h8; progRange = 4'h3; dataRange = 4'h5; modeFixed = 0; periphSel = 0;
    @(negedge clk);
    step(16'h1234, 0, 0, 1, "R1");          // reset holds idle even with a write request
    rst = 0;
    step(16'h0000, 0, 0, 0, "R2");          // no request
    // split mode, boundary at page 8
    step(16'h1000, 1, 1, 0);                // R3 fetch in program pages
    step(16'h9000, 1, 1, 0);                // R3 fetch beyond boundary -> external
    step(16'h2000, 0, 1, 0);                // R3 data read of program page
    step(16'h2000, 0, 0, 1);                // R4 blocked write
    step(16'h2001, 0, 1, 0, "R4");          // violation lasts one cycle
    step(16'h7FFF, 0, 0, 1);                // R4 last program page
    step(16'h8000, 0, 0, 1);                // R3 first data page, write allowed
    step(16'h3ABC, 0, 1, 1, "R9");          // both requests -> write (blocked)
    step(16'h0100, 1, 0, 1, "R9");          // fetch with write request stays a read
    partReg = 4'h0;
    step(16'h0000, 0, 0, 1, "R10");         // new boundary applies at once
    step(16'h0000, 1, 1, 0, "R3");          // nothing is program
    partReg = 4'hF;
    step(16'hF000, 0, 0, 1, "R10");         // all program
    step(16'hFFFF, 1, 1, 0, "R3");
    // independent ranges
    modeFixed = 1;
    step(16'h3FFF, 1, 1, 0);                // R5 highest program page
    step(16'h4000, 1, 1, 0);                // R5 beyond -> external
    step(16'h5FFF, 0, 0, 1);                // R5 write not protected
    step(16'h6000, 0, 0, 1, "R8");          // external write keeps strobe high
    // peripheral windows
    periphSel = 1;
    step(16'h8000, 0, 1, 0);                // R6 low window
    step(16'hBFFF, 0, 0, 1);                // R6 low window write
    step(16'hC000, 0, 1, 0);                // R6 high window
    step(16'hC123, 0, 0, 1, "R7");          // address bus carries low bits
    step(16'h8000, 1, 1, 0, "R6");          // fetches ignore the windows
    modeFixed = 0; partReg = 4'hF;
    step(16'h9000, 0, 0, 1, "R6");          // window wins over protection
    step(16'hC000, 0, 0, 1, "R6");
    step(16'h7000, 0, 0, 1, "R4");          // below windows still protected
    step(16'h4321, 0, 0, 1, "R1");
    rst = 1;
    step(16'hC000, 0, 0, 1, "R1");          // reset mid-stream
    rst = 0;
    for (int i = 0; i < 400; i++) begin
      partReg = 4'($urandom); progRange = 4'($urandom); dataRange = 4'($urandom);
      modeFixed = 1'($urandom); periphSel = 1'($urandom);
      step(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule